// File: doc/BRIEF.md
# Serial Register-Access Slave with Streaming Read and Write

This block lets an off-chip host reach a small bank of 8-bit control and identification registers over a four-wire serial link. The link consists of a serial clock, an active-low select, a data input and a data output. The select, clock and data inputs are brought into the system clock domain through synchronizer chains. Clock edges are found by comparing successive synchronized samples, so all state lives in one clock domain.

A frame opens when select goes low. Its first byte is a command, which picks streaming read or streaming write. Its second byte is a starting address. Every byte after that transfers one register, and the address steps up by one after each byte, for as many bytes as the host sends.

The register contents appear in full on a flat bank output. Bit 0 of one register drives a reset-control output for external logic. An active-low system reset loads every register with its fixed power-on value.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, registers 0..18 hold 00,04,56,11,00,00,00,00,02,01,00,00,00,FF,EF,FF,03,12,04 (hex), in that order. Register i appears on `bank_q[8*i+7:8*i]`, and register 3 is the product identifier 0x11.
- R2: A frame whose command byte is 0x40 returns registers MSB first on `sdo`, one bit per serial clock rising edge. The first data byte comes from the address given in the second byte, and each later byte comes from the next higher address.
- R3: A frame whose command byte is 0x80 writes each data byte to the current address when that byte's eighth rising edge arrives, then advances the address.
- R4: Reading an address at or above 19 returns 0x00. Writing such an address changes no register.
- R5: A command byte other than 0x40 or 0x80 makes the rest of the frame a no-op: no register changes, and `sdo` stays 0 until select rises.
- R6: Raising select in the middle of a byte discards the partial byte. The next frame starts again with a command byte.
- R7: `ext_reset` equals bit 0 of register 11 (0x0B). Writing 0x01 there asserts it and writing 0x00 there releases it.
- R8: The address advances past 0xFF to 0x00 within one frame.
- R9: For each read byte, `sdo` carries the MSB while the serial clock is low, before that byte's first rising edge.
- R10: `rst_n` low returns every register to its reset value and clears the bit count and the command state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sck | input | 1 | Serial clock from the host, idles low |
| csb | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| ext_reset | output | 1 | Reset control, bit 0 of register 11 |
| bank_q | output | NREG*8 (152) | All register contents, register i at bits 8*i+7:8*i |

## Verification
The hardest state to reach from the ports is a frame that select cuts off partway through a byte, after the command and address have already been accepted. In that state a stale bit count or a left-over write mode would corrupt the next frame. The stimulus produces it by clocking in a write command, an address and only a few data bits before raising select, and it also aborts a frame inside the command byte. A later read frame and the bank output then show whether the abandoned bits had any effect. Address wrap is reached by a write stream that starts at 0xFE. The other cases are covered by random streams whose start addresses include the out-of-range region.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   localparam int DW = 8;
   localparam logic [DW-1:0] CMD_READ  = 8'h40;
   localparam logic [DW-1:0] CMD_WRITE = 8'h80;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_DROP = 2'd3
   } phase_t;

   function automatic logic [DW-1:0] reset_value(input int idx);
      case (idx)
         1:       return 8'h04;
         2:       return 8'h56;
         3:       return 8'h11;
         8:       return 8'h02;
         9:       return 8'h01;
         13:      return 8'hFF;
         14:      return 8'hEF;
         15:      return 8'hFF;
         16:      return 8'h03;
         17:      return 8'h12;
         18:      return 8'h04;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic csb,
   input  logic sdi,
   output logic csb_s,
   output logic sdi_s,
   output logic sck_rise,
   output logic sck_fall
);
   logic [STAGES-1:0] sck_ff, csb_ff, sdi_ff;
   logic              sck_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_ff   <= '0;
         csb_ff   <= '1;
         sdi_ff   <= '0;
         sck_last <= 1'b0;
      end else begin
         sck_ff   <= {sck_ff[STAGES-2:0], sck};
         csb_ff   <= {csb_ff[STAGES-2:0], csb};
         sdi_ff   <= {sdi_ff[STAGES-2:0], sdi};
         sck_last <= sck_ff[STAGES-1];
      end
   end

   assign csb_s    = csb_ff[STAGES-1];
   assign sdi_s    = sdi_ff[STAGES-1];
   assign sck_rise =  sck_ff[STAGES-1] & ~sck_last;
   assign sck_fall = ~sck_ff[STAGES-1] &  sck_last;
endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
   import spi_rb_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              sdi_bit,
   output logic              sdo,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DW-1:0]     wr_data,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DW-1:0]     rd_data,
   output phase_t            phase,
   output logic [2:0]        bit_cnt
);
   logic [DW-1:0]     shift_in, shift_out;
   logic [ADDR_W-1:0] addr;
   logic              is_read, load_pend;
   logic [DW-1:0]     byte_now;
   logic              byte_done;

   assign byte_now  = {shift_in[DW-2:0], sdi_bit};
   assign byte_done = cs_active && sck_rise && (bit_cnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         bit_cnt   <= '0;
         shift_in  <= '0;
         shift_out <= '0;
         addr      <= '0;
         is_read   <= 1'b0;
         load_pend <= 1'b0;
      end else if (!cs_active) begin
         phase     <= PH_CMD;
         bit_cnt   <= '0;
         shift_in  <= '0;
         shift_out <= '0;
         load_pend <= 1'b0;
      end else if (sck_rise) begin
         shift_in <= byte_now;
         bit_cnt  <= 3'(bit_cnt + 3'd1);
         if (bit_cnt == 3'd7) begin
            case (phase)
               PH_CMD: begin
                  if (byte_now == CMD_READ) begin
                     is_read <= 1'b1;
                     phase   <= PH_ADDR;
                  end else if (byte_now == CMD_WRITE) begin
                     is_read <= 1'b0;
                     phase   <= PH_ADDR;
                  end else begin
                     phase   <= PH_DROP;
                  end
               end
               PH_ADDR: begin
                  addr      <= byte_now[ADDR_W-1:0];
                  phase     <= PH_DATA;
                  load_pend <= is_read;
               end
               PH_DATA: begin
                  if (is_read) load_pend <= 1'b1;
                  else         addr      <= ADDR_W'(addr + 1'b1);
               end
               default: ;
            endcase
         end
      end else if (sck_fall) begin
         if (load_pend) begin
            shift_out <= rd_data;
            addr      <= ADDR_W'(addr + 1'b1);
            load_pend <= 1'b0;
         end else begin
            shift_out <= {shift_out[DW-2:0], 1'b0};
         end
      end
   end

   assign sdo     = shift_out[DW-1];
   assign wr_en   = byte_done && (phase == PH_DATA) && !is_read;
   assign wr_addr = addr;
   assign wr_data = byte_now;
   assign rd_addr = addr;
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
   import spi_rb_pkg::*;
#(
   parameter int NREG    = 19,
   parameter int ADDR_W  = 8,
   parameter int RST_REG = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] bank_q,
   output logic               ext_reset
);
   logic [DW-1:0] mem [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= reset_value(g);
         else if (wr_en && wr_addr == ADDR_W'(g))
            mem[g] <= wr_data;
      end
      assign bank_q[g*DW +: DW] = mem[g];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_addr == ADDR_W'(i)) rd_data = mem[i];
   end

   assign ext_reset = mem[RST_REG][0];
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
   import spi_rb_pkg::*;
#(
   parameter int NREG        = 19,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RST_REG     = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               csb,
   input  logic               sdi,
   output logic               sdo,
   output logic               ext_reset,
   output logic [NREG*DW-1:0] bank_q
);
   if (NREG < 1 || NREG > (1 << ADDR_W)) begin : g_bad_nreg
      $error("NREG must be between 1 and 2**ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RST_REG >= NREG) begin : g_bad_rst
      $error("RST_REG must name an implemented register");
   end

   logic              csb_s, sdi_s, sck_rise, sck_fall;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DW-1:0]     wr_data, rd_data;
   phase_t            phase;
   logic [2:0]        bit_cnt;

   spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .sdi(sdi),
      .csb_s(csb_s), .sdi_s(sdi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
   );

   spi_rb_engine #(.ADDR_W(ADDR_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .cs_active(!csb_s),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_bit(sdi_s),
      .sdo(sdo), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .phase(phase), .bit_cnt(bit_cnt)
   );

   spi_rb_regfile #(.NREG(NREG), .ADDR_W(ADDR_W), .RST_REG(RST_REG)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .bank_q(bank_q), .ext_reset(ext_reset)
   );
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk
   import spi_rb_pkg::*;
#(
   parameter int NREG    = 19,
   parameter int ADDR_W  = 8,
   parameter int RST_REG = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               csb_s,
   input phase_t             phase,
   input logic [2:0]         bit_cnt,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DW-1:0]      wr_data,
   input logic [NREG*DW-1:0] bank_q,
   input logic               ext_reset,
   input logic               sdo
);
   function automatic logic [NREG*DW-1:0] build_rst();
      logic [NREG*DW-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*DW +: DW] = reset_value(i);
      return v;
   endfunction
   localparam logic [NREG*DW-1:0] RST_VEC = build_rst();

   logic [ADDR_W-1:0] cap_addr;
   logic [DW-1:0]     cap_data;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         cap_addr <= wr_addr;
         cap_data <= wr_data;
      end
   end

   // R6
   csb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csb_s |=> (phase == PH_CMD && bit_cnt == 3'd0));
   // R5
   drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DROP) |-> !wr_en);
   // R5
   drop_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DROP) |-> !sdo);
   // R3
   write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr < ADDR_W'(NREG)) |=> bank_q[int'(cap_addr)*DW +: DW] == cap_data);
   // R4
   oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= ADDR_W'(NREG)) |=> $stable(bank_q));
   // R7
   ext_reset_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_reset) |-> $past(wr_en && wr_addr == ADDR_W'(RST_REG) && wr_data[0]));
   // R10
   reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> bank_q == RST_VEC);
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(
   .NREG(NREG), .ADDR_W(ADDR_W), .RST_REG(RST_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .csb_s(csb_s), .phase(phase), .bit_cnt(bit_cnt),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bank_q(bank_q),
   .ext_reset(ext_reset), .sdo(sdo)
);

// File: tb/sim_spi_regbank_slave.sv
module sim_spi_regbank_slave;
   localparam int NREG = 19;
   localparam int HP   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, csb = 1'b1, sdi = 1'b0;
   logic sdo, ext_reset;
   logic [NREG*8-1:0] bank_q;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_mem [NREG];

   always #2 clk = ~clk;

   spi_regbank_slave u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .sdi(sdi),
      .sdo(sdo), .ext_reset(ext_reset), .bank_q(bank_q)
   );

   function automatic logic [7:0] init_val(input int i);
      logic [7:0] t [NREG] = '{8'h00, 8'h04, 8'h56, 8'h11, 8'h00, 8'h00, 8'h00,
                               8'h00, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00, 8'hFF,
                               8'hEF, 8'hFF, 8'h03, 8'h12, 8'h04};
      return t[i];
   endfunction

   function automatic logic [7:0] model_rd(input int a);
      return (a < NREG) ? exp_mem[a] : 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_bank(input string tag);
      for (int i = 0; i < NREG; i++) chk(tag, 32'(bank_q[i*8 +: 8]), 32'(exp_mem[i]));
      chk({tag, " R7 ext_reset"}, 32'(ext_reset), 32'(exp_mem[11][0]));
   endtask

   task automatic frame_open();
      csb = 1'b0; sck = 1'b0; sdi = 1'b0;
      #(HP);
   endtask

   task automatic frame_close();
      #(HP);
      csb = 1'b1;
      #(2*HP);
   endtask

   task automatic xfer_bits(input logic [7:0] dout, input int nbits, output logic [7:0] din);
      din = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         sdi = dout[i];
         #(HP);
         din[i] = sdo;
         sck = 1'b1;
         #(HP);
         sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] dout, output logic [7:0] din);
      xfer_bits(dout, 8, din);
   endtask

   task automatic write_stream(input logic [7:0] a, input logic [7:0] d [], input int n);
      logic [7:0] junk;
      frame_open();
      xfer(8'h80, junk);
      xfer(a, junk);
      for (int k = 0; k < n; k++) begin
         xfer(d[k], junk);
         if (int'(8'(a + k)) < NREG) exp_mem[8'(a + k)] = d[k];
      end
      frame_close();
   endtask

   task automatic read_check(input string tag, input logic [7:0] a, input int n);
      logic [7:0] junk, got;
      frame_open();
      xfer(8'h40, junk);
      xfer(a, junk);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, got);
         chk(tag, 32'(got), 32'(model_rd(int'(8'(a + k)))));
      end
      frame_close();
   endtask

   initial begin
      #(4*150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] junk, got;
      logic [7:0] d [];
      void'($urandom(32'h1A2B));
      for (int i = 0; i < NREG; i++) exp_mem[i] = init_val(i);
      #40;
      rst_n = 1'b1;
      #40;

      // R1 R10: reset state
      check_bank("R1 reset bank");
      chk("R1 sdo idle", 32'(sdo), 32'd0);

      // R2 R9 R4: stream read of every register and past the end
      read_check("R2 R9 R4 stream read from 0", 8'h00, NREG + 2);
      read_check("R2 read product id", 8'h03, 1);

      // R7: reset control register
      d = new[1];
      d[0] = 8'h01;
      write_stream(8'h0B, d, 1);
      chk("R7 ext_reset asserted", 32'(ext_reset), 32'd1);
      d[0] = 8'h00;
      write_stream(8'h0B, d, 1);
      chk("R7 ext_reset released", 32'(ext_reset), 32'd0);

      // R3: directed stream write across several registers
      d = new[3];
      d[0] = 8'hA5; d[1] = 8'h3C; d[2] = 8'h7E;
      write_stream(8'h04, d, 3);
      check_bank("R3 stream write");
      read_check("R3 read back", 8'h04, 3);

      // R4: out-of-range write then read
      d = new[2];
      d[0] = 8'h99; d[1] = 8'h66;
      write_stream(8'h20, d, 2);
      check_bank("R4 oob write no effect");
      read_check("R4 oob read zero", 8'h20, 2);

      // R5: unknown command
      frame_open();
      xfer(8'h33, junk);
      xfer(8'h05, got);
      chk("R5 sdo zero after bad cmd", 32'(got), 32'd0);
      xfer(8'hFF, got);
      chk("R5 sdo zero after bad cmd", 32'(got), 32'd0);
      frame_close();
      check_bank("R5 bad cmd no write");

      // R6: abort inside a data byte, then inside a command byte
      frame_open();
      xfer(8'h80, junk);
      xfer(8'h05, junk);
      xfer_bits(8'hFF, 4, junk);
      frame_close();
      check_bank("R6 partial data byte discarded");
      frame_open();
      xfer_bits(8'h40, 3, junk);
      frame_close();
      read_check("R6 new frame starts with command", 8'h05, 1);

      // R8: address wrap
      d = new[3];
      d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'hC3;
      write_stream(8'hFE, d, 3);
      check_bank("R8 wrap write");
      read_check("R8 wrap read", 8'hFF, 2);

      // R2 R3 R4: random streams
      for (int f = 0; f < 20; f++) begin
         int n;
         logic [7:0] a;
         a = 8'($urandom_range(0, NREG + 2));
         n = int'($urandom_range(1, 4));
         d = new[n];
         for (int k = 0; k < n; k++) d[k] = 8'($urandom);
         write_stream(a, d, n);
         check_bank("R3 random write");
         read_check("R2 random read", a, n + 1);
      end

      // R10: system reset restores everything
      frame_open();
      xfer(8'h80, junk);
      rst_n = 1'b0;
      #40;
      rst_n = 1'b1;
      csb = 1'b1;
      #(2*HP);
      for (int i = 0; i < NREG; i++) exp_mem[i] = init_val(i);
      check_bank("R10 reset restores bank");
      read_check("R10 state cleared", 8'h00, 4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule